// File: doc/BRIEF.md
# USB Bus Reset Detector

This block watches the upstream differential pair of a full-speed USB function for a single-ended-zero (SE0) state, meaning both lines are low. It runs in the 12 MHz core clock domain. The raw line levels are first re-timed through a synchronizer. A run counter then measures how long the SE0 lasts without a break. A run that reaches the detection threshold counts as a bus reset. The default threshold is 168 samples, which is 14 µs at 12 MHz. It lies between the shortest SE0 that must be ignored and the longest SE0 that must always count as a reset.

When the block declares a reset, it does three things in the same cycle:
- it sets a sticky status flag that software can read;
- it pulses a strobe that wipes the device-address and hub-port registers elsewhere in the chip;
- it pulses an abort strobe if the power-on start-up delay is still counting.

The reset interrupt request does not fire at detection. It fires for one cycle once the SE0 is released. All control and status pins are plain levels or single-cycle pulses. There is no streaming interface.

Top module: `usb_busreset_detect`

## Requirements
- R1: An SE0 sample is a cycle in which both synchronized line levels are 0. A state with only one line low never counts toward a reset.
- R2: A run of 167 consecutive SE0 samples never produces a detection. The status flag stays 0 and no strobe or interrupt is issued.
- R3: The 168th consecutive SE0 sample produces a detection. The status flag and the register-clear strobe rise 170 clock cycles after both input lines first go low: two synchronizer stages plus 168 samples.
- R4: Any non-SE0 sample restarts the run count from zero. Two SE0 runs of 100 samples, split by one idle sample, produce no detection.
- R5: The register-clear strobe is high for exactly one cycle per reset event. It is not repeated while the SE0 continues.
- R6: After a detection, the interrupt request is held low while the SE0 lasts. It is high for exactly one cycle after the SE0 ends.
- R7: An SE0 that ends without a detection produces no interrupt request.
- R8: The status flag stays set through idle bus cycles until the clear strobe is asserted. The clear strobe then returns it to 0.
- R9: When a detection and the clear strobe occur in the same cycle, the status flag ends up set.
- R10: The abort strobe pulses for one cycle together with the register-clear strobe, but only when the start-up-delay-active input is high in the detection cycle. Otherwise it stays 0.
- R11: During and right after reset, the status flag, the register-clear strobe, the interrupt request and the abort strobe are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12 MHz core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_p | input | 1 | Raw D+ level |
| line_n | input | 1 | Raw D– level |
| flag_clr | input | 1 | Software strobe that clears the status flag |
| boot_delay_busy | input | 1 | High while the power-on start-up delay is running |
| reset_seen | output | 1 | Sticky bus-reset status flag |
| regs_wipe | output | 1 | One-cycle pulse clearing address and hub-port registers |
| reset_irq | output | 1 | One-cycle interrupt request on SE0 release |
| boot_abort | output | 1 | One-cycle pulse aborting the start-up delay |

## Verification
The hardest case to reach from the ports is a software clear that lands in exactly the cycle a detection is registered. A slip of one cycle in either direction would test something else. The bench counts the cycles from the moment both lines are driven low and raises the clear strobe so that it is sampled at the 170th edge. It then checks that the flag is set. The threshold boundary is reached the same way, using SE0 runs held for exactly 167 and 168 sampled cycles.

// File: rtl/usbrst_pkg.sv
package usbrst_pkg;
  typedef enum logic [0:0] {
    ST_WATCH = 1'b0,
    ST_HELD  = 1'b1
  } det_state_e;
endpackage

// File: rtl/usbrst_sync.sv
module usbrst_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[LAST];
  end
endmodule

// File: rtl/usbrst_run_cnt.sv
module usbrst_run_cnt #(
  parameter int THRESH = 168
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se0,
  output logic hit
);
  localparam int CNT_W = $clog2(THRESH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(THRESH - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!se0)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign hit = se0 && (cnt == LAST);

  // R4: a non-SE0 sample restarts the run
  p_run_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !se0 |=> (cnt == '0));
endmodule

// File: rtl/usbrst_ctrl.sv
module usbrst_ctrl
  import usbrst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic se0,
  input  logic flag_clr,
  input  logic boot_delay_busy,
  output logic reset_seen,
  output logic regs_wipe,
  output logic reset_irq,
  output logic boot_abort
);
  det_state_e state;
  logic       new_event;

  assign new_event = (state == ST_WATCH) && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_WATCH;
      regs_wipe  <= 1'b0;
      reset_irq  <= 1'b0;
      boot_abort <= 1'b0;
    end else begin
      regs_wipe  <= 1'b0;
      reset_irq  <= 1'b0;
      boot_abort <= 1'b0;
      case (state)
        ST_WATCH: if (hit) begin
          state      <= ST_HELD;
          regs_wipe  <= 1'b1;
          boot_abort <= boot_delay_busy;
        end
        ST_HELD: if (!se0) begin
          state     <= ST_WATCH;
          reset_irq <= 1'b1;
        end
        default: state <= ST_WATCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reset_seen <= 1'b0;
    else if (new_event) reset_seen <= 1'b1;
    else if (flag_clr)  reset_seen <= 1'b0;
  end

  // R5: wipe strobe lasts one cycle
  p_wipe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    regs_wipe |=> !regs_wipe);
  // R3: wipe strobe and status flag rise together
  p_wipe_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    regs_wipe |-> reset_seen);
  // R10: abort only alongside a wipe
  p_abort_with_wipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    boot_abort |-> regs_wipe);
  // R6: interrupt only after the line has left SE0
  p_irq_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_irq |-> $past(!se0));
  // R8: flag is sticky without a clear
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_seen && !flag_clr) |=> reset_seen);
endmodule

// File: rtl/usb_busreset_detect.sv
module usb_busreset_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int DETECT_RUN  = 168
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_p,
  input  logic line_n,
  input  logic flag_clr,
  input  logic boot_delay_busy,
  output logic reset_seen,
  output logic regs_wipe,
  output logic reset_irq,
  output logic boot_abort
);
  logic [1:0] lines_s;
  logic       se0;
  logic       hit;

  usbrst_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({line_p, line_n}),
    .dout (lines_s)
  );

  // R1: SE0 only when both re-timed lines are low
  assign se0 = ~lines_s[1] & ~lines_s[0];

  usbrst_run_cnt #(.THRESH(DETECT_RUN)) u_run (
    .clk  (clk),
    .rst_n(rst_n),
    .se0  (se0),
    .hit  (hit)
  );

  usbrst_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .hit            (hit),
    .se0            (se0),
    .flag_clr       (flag_clr),
    .boot_delay_busy(boot_delay_busy),
    .reset_seen     (reset_seen),
    .regs_wipe      (regs_wipe),
    .reset_irq      (reset_irq),
    .boot_abort     (boot_abort)
  );

  // R1: a detection needs an SE0 on the re-timed lines
  p_hit_needs_se0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(regs_wipe) |-> $past(se0));
endmodule

// File: tb/usb_busreset_detect_test.sv
module usb_busreset_detect_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_p = 1'b1, line_n = 1'b0;
  logic flag_clr = 1'b0, boot_delay_busy = 1'b0;
  logic reset_seen, regs_wipe, reset_irq, boot_abort;

  int n_chk = 0, n_bad = 0;
  int n_wipe = 0, n_irq = 0, n_abort = 0;

  always #2 clk = ~clk;

  usb_busreset_detect uut (
    .clk(clk), .rst_n(rst_n), .line_p(line_p), .line_n(line_n),
    .flag_clr(flag_clr), .boot_delay_busy(boot_delay_busy),
    .reset_seen(reset_seen), .regs_wipe(regs_wipe),
    .reset_irq(reset_irq), .boot_abort(boot_abort)
  );

  always @(negedge clk) begin
    if (regs_wipe)  n_wipe++;
    if (reset_irq)  n_irq++;
    if (boot_abort) n_abort++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_wipe = 0; n_irq = 0; n_abort = 0;
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1 line_p = 1'b1; line_n = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic se0_for(input int n);
    @(posedge clk); #1 line_p = 1'b0; line_n = 1'b0;
    repeat (n) @(posedge clk);
    #1 line_p = 1'b1;
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic soft_clear();
    @(posedge clk); #1 flag_clr = 1'b1;
    @(posedge clk); #1 flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk(reset_seen == 0, "R11 flag", reset_seen, 0);
    chk(regs_wipe == 0 && reset_irq == 0 && boot_abort == 0, "R11 strobes",
        regs_wipe + reset_irq + boot_abort, 0);
  endtask

  task automatic t_one_line();
    clear_counts();
    @(posedge clk); #1 line_p = 1'b0; line_n = 1'b1;
    repeat (300) @(posedge clk);
    idle(6);
    chk(n_wipe == 0, "R1 one line low wipes", n_wipe, 0);
    chk(reset_seen == 0, "R1 one line low flag", reset_seen, 0);
  endtask

  task automatic t_short();
    clear_counts();
    se0_for(167);
    chk(n_wipe == 0, "R2 167 samples wipes", n_wipe, 0);
    chk(reset_seen == 0, "R2 167 samples flag", reset_seen, 0);
    chk(n_irq == 0, "R7 no irq without detection", n_irq, 0);
  endtask

  task automatic t_glitch();
    clear_counts();
    @(posedge clk); #1 line_p = 1'b0; line_n = 1'b0;
    repeat (100) @(posedge clk);
    #1 line_p = 1'b1;
    @(posedge clk); #1 line_p = 1'b0;
    repeat (100) @(posedge clk);
    idle(6);
    chk(n_wipe == 0, "R4 split run wipes", n_wipe, 0);
    chk(reset_seen == 0, "R4 split run flag", reset_seen, 0);
  endtask

  task automatic t_exact();
    clear_counts();
    boot_delay_busy = 1'b0;
    se0_for(168);
    chk(n_wipe == 1, "R3 168 samples wipe", n_wipe, 1);
    chk(reset_seen == 1, "R3 168 samples flag", reset_seen, 1);
    chk(n_irq == 1, "R6 irq after release", n_irq, 1);
    chk(n_abort == 0, "R10 no abort when delay idle", n_abort, 0);
  endtask

  task automatic t_sticky();
    idle(50);
    chk(reset_seen == 1, "R8 flag held while idle", reset_seen, 1);
    soft_clear();
    #1 chk(reset_seen == 0, "R8 flag cleared", reset_seen, 0);
  endtask

  task automatic t_latency();
    clear_counts();
    @(posedge clk); #1 line_p = 1'b0; line_n = 1'b0;
    repeat (169) @(posedge clk);
    #1 chk(regs_wipe == 0, "R3 no wipe before edge 170", regs_wipe, 0);
    @(posedge clk); #1;
    chk(regs_wipe == 1, "R3 wipe at edge 170", regs_wipe, 1);
    chk(reset_seen == 1, "R3 flag at edge 170", reset_seen, 1);
    repeat (300) @(posedge clk);
    #1;
    chk(n_wipe == 1, "R5 single wipe in long SE0", n_wipe, 1);
    chk(n_irq == 0, "R6 no irq while SE0 held", n_irq, 0);
    line_p = 1'b1;
    repeat (6) @(posedge clk);
    #1 chk(n_irq == 1, "R6 one irq on release", n_irq, 1);
    soft_clear();
  endtask

  task automatic t_abort();
    clear_counts();
    boot_delay_busy = 1'b1;
    se0_for(200);
    chk(n_abort == 1, "R10 abort while delay busy", n_abort, 1);
    boot_delay_busy = 1'b0;
    soft_clear();
  endtask

  task automatic t_race();
    clear_counts();
    @(posedge clk); #1 line_p = 1'b0; line_n = 1'b0;
    repeat (169) @(posedge clk);
    #1 flag_clr = 1'b1;
    @(posedge clk); #1 flag_clr = 1'b0;
    chk(reset_seen == 1, "R9 detection beats clear", reset_seen, 1);
    line_p = 1'b1;
    repeat (6) @(posedge clk);
    #1 chk(n_wipe == 1, "R9 wipe issued", n_wipe, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_one_line();
    t_short();
    t_glitch();
    t_exact();
    t_sticky();
    t_latency();
    t_abort();
    t_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule